// File: doc/BRIEF.md
# Serial Register Slave for Regulator Controls

This block is a two-wire serial slave that runs entirely on a fast system clock. It passes the bus clock and data lines through a synchronizer and finds their edges inside the system clock domain. It holds a small register file that drives a bank of regulator controls: four enable bits, the output-voltage select codes of three regulators, and the select and trim codes of a fourth regulator. The slave answers to one fixed 7-bit address. It never holds the bus clock low, and it drives data only by asserting an open-drain pull-down enable.

Each transfer carries exactly one register byte. A write sends the address with the write bit, then a register index, then one data byte, then STOP. A read sends the address with the write bit and the register index, then a repeated START, then the address with the read bit. The slave returns one byte, and the master answers with NACK and STOP.

The control FSM has these states: `ST_IDLE` (waiting for START), `ST_DEV` (receiving the address byte), `ST_DEV_ACK`, `ST_IDX` (receiving the index), `ST_IDX_ACK`, `ST_WDATA`, `ST_WDATA_ACK`, `ST_RDATA` (shifting a byte out), `ST_RACK` (the master's acknowledge bit) and `ST_WAIT` (ignoring the bus). Its transitions are:
- Any STOP leads to `ST_IDLE`.
- Any START, including a repeated one, leads to `ST_DEV`.
- `ST_DEV` goes to `ST_DEV_ACK` on an address match and to `ST_WAIT` otherwise.
- `ST_DEV_ACK` goes to `ST_IDX` for a write and to `ST_RDATA` for a read.
- `ST_IDX` goes to `ST_IDX_ACK`, then `ST_WDATA`, then `ST_WDATA_ACK`, then `ST_WAIT`.
- `ST_RDATA` goes to `ST_RACK`, then `ST_WAIT`.

Every one of these moves happens on a bus-clock falling edge.

Top module: `regctl_i2c_slave`

## Requirements
- R1: After reset the four enables read 4'b1111, every select and trim field is 0, and the pull-down enable is off.
- R2: A write to index 0x00 is acknowledged on the address, index and data bytes, and data bits 3:0 become the enables (bit 3 drives `en_o[3]` down to bit 0 driving `en_o[0]`).
- R3: An address other than 7'b1001000 gets no acknowledge on any byte, and the register fields do not change.
- R4: A write to index 0x08 loads select1 from data bit 4, select2 from bit 3, and the 2-bit select3 from bits 2:1.
- R5: A write to index 0x0A loads the 2-bit select4 from data bits 3:2 and the 2-bit trim code from bits 1:0.
- R6: A read (address+W, index, repeated START, address+R) returns the addressed register MSB first, with unused bits reading 0: 0x00 gives {4'b0, enables}, 0x08 gives {3'b0, select1, select2, select3, 1'b0}, and 0x0A gives {4'b0, select4, trim}.
- R7: A read of any index other than 0x00, 0x08 or 0x0A returns 0xFF.
- R8: A write to an unmapped index is acknowledged on all three bytes and changes no field.
- R9: The pull-down enable changes only while the synchronized bus clock is low.
- R10: A STOP before the data byte completes ends the transfer without changing any field.
- R11: A second data byte in one write is not acknowledged and is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line (wired level) |
| sda_oe | output | 1 | 1 pulls the data line low |
| en_o | output | 4 | Regulator enables, bit n for regulator n+1 |
| sel1_o | output | 1 | Regulator 1 voltage select |
| sel2_o | output | 1 | Regulator 2 voltage select |
| sel3_o | output | 2 | Regulator 3 voltage select |
| sel4_o | output | 2 | Regulator 4 voltage select |
| trim_o | output | 2 | Regulator 4 trim code |

## Verification
Each bus edge reaches the FSM three system clocks after it appears on the pin: two synchronizer flops and one edge-detect flop. So the acknowledge pull-down and each read data bit appear about three cycles after a bus-clock falling edge. The bench holds every bus phase for 32 system clocks and samples the wired data line only in the middle of the clock-high phase, well after that latency and before the next edge. A register field changes one cycle after the falling edge that follows the eighth data bit. The bench therefore compares fields only after STOP, and a per-cycle monitor flags any pull-down change while the bench holds the bus clock high.

// File: rtl/regctl_pkg.sv
package regctl_pkg;

    localparam int BYTE_BITS = 8;
    localparam int CNT_W     = $clog2(BYTE_BITS + 1);

    localparam logic [7:0] IDX_ENABLE = 8'h00;
    localparam logic [7:0] IDX_SELECT = 8'h08;
    localparam logic [7:0] IDX_TRIM   = 8'h0A;
    localparam logic [7:0] RD_UNMAPPED = 8'hFF;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_IDX,
        ST_IDX_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_WAIT
    } xfer_state_t;

    typedef struct packed {
        logic [3:0] en;
        logic       sel1;
        logic       sel2;
        logic [1:0] sel3;
        logic [1:0] sel4;
        logic [1:0] trim;
    } reg_fields_t;

    localparam reg_fields_t FIELDS_RESET = '{en: 4'hF, sel1: 1'b0, sel2: 1'b0,
                                             sel3: 2'b00, sel4: 2'b00, trim: 2'b00};

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] prev;

    assign raw = {sda_i, scl_i};

    // One synchronizer chain per bus line; lines idle high.
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '1;
            end else begin
                chain <= {chain[STAGES-2:0], raw[g]};
            end
        end
        assign synced[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= '1;
        end else begin
            prev <= synced;
        end
    end

    assign scl_s     = synced[0];
    assign sda_s     = synced[1];
    assign scl_rise  = synced[0] & ~prev[0];
    assign scl_fall  = ~synced[0] & prev[0];
    assign start_det = synced[0] & prev[0] & prev[1] & ~synced[1];
    assign stop_det  = synced[0] & prev[0] & ~prev[1] & synced[1];

endmodule

// File: rtl/i2c_xfer_fsm.sv
module i2c_xfer_fsm
    import regctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h48
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_s,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [7:0] rd_data,
    output logic [7:0] idx,
    output logic [7:0] wdata,
    output logic       wr_en,
    output logic       sda_oe
);
    xfer_state_t state, state_nx;

    logic [CNT_W-1:0]     bit_cnt;
    logic [BYTE_BITS-1:0] shreg;
    logic [BYTE_BITS-1:0] tx_q;
    logic                 rw_q;
    logic                 byte_full;
    logic                 addr_hit;
    logic                 unused_bits;

    assign byte_full   = (bit_cnt == CNT_W'(BYTE_BITS));
    assign addr_hit    = (shreg[7:1] == DEV_ADDR);
    assign wdata       = shreg;
    assign unused_bits = tx_q[7];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state decode
    always_comb begin
        state_nx = state;
        if (stop_det) begin
            state_nx = ST_IDLE;
        end else if (start_det) begin
            state_nx = ST_DEV;
        end else begin
            unique case (state)
                ST_IDLE, ST_WAIT: state_nx = state;
                ST_DEV: begin
                    if (scl_fall && byte_full) state_nx = addr_hit ? ST_DEV_ACK : ST_WAIT;
                end
                ST_DEV_ACK: begin
                    if (scl_fall) state_nx = rw_q ? ST_RDATA : ST_IDX;
                end
                ST_IDX: begin
                    if (scl_fall && byte_full) state_nx = ST_IDX_ACK;
                end
                ST_IDX_ACK: begin
                    if (scl_fall) state_nx = ST_WDATA;
                end
                ST_WDATA: begin
                    if (scl_fall && byte_full) state_nx = ST_WDATA_ACK;
                end
                ST_WDATA_ACK: begin
                    if (scl_fall) state_nx = ST_WAIT;
                end
                ST_RDATA: begin
                    if (scl_fall && byte_full) state_nx = ST_RACK;
                end
                ST_RACK: begin
                    if (scl_fall) state_nx = ST_WAIT;
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            tx_q    <= '0;
            rw_q    <= 1'b0;
            idx     <= '0;
            wr_en   <= 1'b0;
            sda_oe  <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (stop_det || start_det) begin
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else begin
                unique case (state)
                    ST_DEV, ST_IDX, ST_WDATA: begin
                        if (scl_rise && !byte_full) begin
                            shreg   <= {shreg[BYTE_BITS-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                        if (scl_fall && byte_full) begin
                            bit_cnt <= '0;
                            if (state == ST_DEV) begin
                                rw_q   <= shreg[0];
                                sda_oe <= addr_hit;
                            end else if (state == ST_IDX) begin
                                idx    <= shreg;
                                sda_oe <= 1'b1;
                            end else begin
                                wr_en  <= 1'b1;
                                sda_oe <= 1'b1;
                            end
                        end
                    end
                    ST_DEV_ACK: begin
                        if (scl_fall) begin
                            if (rw_q) begin
                                tx_q   <= rd_data;
                                sda_oe <= ~rd_data[7];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_IDX_ACK, ST_WDATA_ACK: begin
                        if (scl_fall) sda_oe <= 1'b0;
                    end
                    ST_RDATA: begin
                        if (scl_rise && !byte_full) bit_cnt <= bit_cnt + 1'b1;
                        if (scl_fall) begin
                            if (byte_full) begin
                                sda_oe  <= 1'b0;
                                bit_cnt <= '0;
                            end else if (bit_cnt != '0) begin
                                tx_q   <= {tx_q[BYTE_BITS-2:0], 1'b0};
                                sda_oe <= ~tx_q[6];
                            end
                        end
                    end
                    ST_RACK: sda_oe <= 1'b0;
                    ST_IDLE, ST_WAIT: sda_oe <= 1'b0;
                    default: sda_oe <= 1'b0;
                endcase
            end
        end
    end

    // R9: the pull-down moves only while the synchronized bus clock is low
    a_r9_oe_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R2: every acknowledge slot of a matched transfer holds the line low
    a_r2_ack_slot_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV_ACK || state == ST_IDX_ACK || state == ST_WDATA_ACK) |-> sda_oe);

    // R3 / R11: an ignored transfer never pulls the line
    a_r3_wait_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT || state == ST_IDLE) |-> !sda_oe);

    // R10: a STOP always lands the FSM in idle
    a_r10_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE));

endmodule

// File: rtl/regctl_regfile.sv
module regctl_regfile
    import regctl_pkg::*;
#(
    parameter int N_EN = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  idx,
    input  logic [7:0]  wdata,
    output logic [7:0]  rd_data,
    output reg_fields_t fields
);
    logic unused_bits;
    assign unused_bits = ^wdata[7:5];

    // Enable bits: one flop per regulator
    for (genvar g = 0; g < N_EN; g++) begin : g_en
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                fields.en[g] <= FIELDS_RESET.en[g];
            end else if (wr_en && idx == IDX_ENABLE) begin
                fields.en[g] <= wdata[g];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fields.sel1 <= FIELDS_RESET.sel1;
            fields.sel2 <= FIELDS_RESET.sel2;
            fields.sel3 <= FIELDS_RESET.sel3;
        end else if (wr_en && idx == IDX_SELECT) begin
            fields.sel1 <= wdata[4];
            fields.sel2 <= wdata[3];
            fields.sel3 <= wdata[2:1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fields.sel4 <= FIELDS_RESET.sel4;
            fields.trim <= FIELDS_RESET.trim;
        end else if (wr_en && idx == IDX_TRIM) begin
            fields.sel4 <= wdata[3:2];
            fields.trim <= wdata[1:0];
        end
    end

    always_comb begin
        unique case (idx)
            IDX_ENABLE: rd_data = {4'b0, fields.en};
            IDX_SELECT: rd_data = {3'b0, fields.sel1, fields.sel2, fields.sel3, 1'b0};
            IDX_TRIM:   rd_data = {4'b0, fields.sel4, fields.trim};
            default:    rd_data = RD_UNMAPPED;
        endcase
    end

    // R8 / R10: fields move only on a write strobe
    a_r8_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(fields));

    // R8: a strobe to an unmapped index leaves every field alone
    a_r8_unmapped_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx != IDX_ENABLE && idx != IDX_SELECT && idx != IDX_TRIM) |=> $stable(fields));

endmodule

// File: rtl/regctl_i2c_slave.sv
module regctl_i2c_slave
    import regctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1001000,
    parameter int         SYNC_STAGES = 2,
    parameter int         N_EN        = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [3:0] en_o,
    output logic       sel1_o,
    output logic       sel2_o,
    output logic [1:0] sel3_o,
    output logic [1:0] sel4_o,
    output logic [1:0] trim_o
);
    logic        scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0]  idx, wdata, rd_data;
    logic        wr_en;
    reg_fields_t fields;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_xfer_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .idx       (idx),
        .wdata     (wdata),
        .wr_en     (wr_en),
        .sda_oe    (sda_oe)
    );

    regctl_regfile #(.N_EN(N_EN)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .idx     (idx),
        .wdata   (wdata),
        .rd_data (rd_data),
        .fields  (fields)
    );

    assign en_o   = fields.en;
    assign sel1_o = fields.sel1;
    assign sel2_o = fields.sel2;
    assign sel3_o = fields.sel3;
    assign sel4_o = fields.sel4;
    assign trim_o = fields.trim;

endmodule

// File: tb/regctl_i2c_slave_tb.sv
module regctl_i2c_slave_tb;
    localparam int         Q    = 32;
    localparam logic [6:0] ADDR = 7'b1001000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic [3:0] en_o;
    logic       sel1_o, sel2_o;
    logic [1:0] sel3_o, sel4_o, trim_o;
    wire        sda_line = sda_m & ~sda_oe;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    string tag_q[$];
    int obs_q[$];
    int r9_bad = 0;
    logic oe_prev = 1'b0;

    always #10 clk = ~clk;

    regctl_i2c_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .en_o(en_o), .sel1_o(sel1_o), .sel2_o(sel2_o), .sel3_o(sel3_o),
        .sel4_o(sel4_o), .trim_o(trim_o)
    );

    // Scoreboard monitor: pairs observed items with queued expectations
    always @(negedge clk) begin
        while (obs_q.size() > 0) begin
            int v, e;
            string t;
            v = obs_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (v != e) begin
                errors++;
                $display("FAIL %s: actual=0x%0h expected=0x%0h", t, v, e);
            end
        end
    end

    // R9 monitor: pull-down must not move while the bus clock is high
    always @(negedge clk) begin
        if (rst_n && sda_oe != oe_prev && scl_m) r9_bad++;
        oe_prev <= sda_oe;
    end

    task automatic expect_val(string tag, int v);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic observe(int v);
        obs_q.push_back(v);
    endtask

    task automatic wq(int n = 1);
        repeat (n * Q) @(negedge clk);
    endtask

    function automatic int field_word();
        return {20'b0, en_o, sel1_o, sel2_o, sel3_o, sel4_o, trim_o};
    endfunction

    task automatic chk_fields(string tag, int exp);
        expect_val(tag, exp);
        observe(field_word());
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq(2);
    endtask

    task automatic send_byte(logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq();
            scl_m = 1'b1; wq(2);
            scl_m = 1'b0;
        end
        wq();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        acked = (sda_line == 1'b0);
        wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic recv_byte(output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq();
            scl_m = 1'b1; wq();
            b[i] = sda_line;
            wq();
            scl_m = 1'b0;
        end
        wq();
        sda_m = 1'b1; wq();       // master NACK
        scl_m = 1'b1; wq(2);
        scl_m = 1'b0; wq();
    endtask

    task automatic send_acked(logic [7:0] b, int exp_ack, string tag);
        bit a;
        send_byte(b, a);
        expect_val(tag, exp_ack);
        observe(int'(a));
    endtask

    task automatic wr_txn(logic [7:0] idx, logic [7:0] d, string tag);
        bus_start();
        send_acked({ADDR, 1'b0}, 1, {tag, " addr ack"});
        send_acked(idx, 1, {tag, " index ack"});
        send_acked(d, 1, {tag, " data ack"});
        bus_stop();
    endtask

    task automatic rd_txn(logic [7:0] idx, int exp, string tag);
        logic [7:0] b;
        bus_start();
        send_acked({ADDR, 1'b0}, 1, {tag, " addr ack"});
        send_acked(idx, 1, {tag, " index ack"});
        bus_start();                               // repeated START
        send_acked({ADDR, 1'b1}, 1, {tag, " read addr ack"});
        recv_byte(b);
        bus_stop();
        expect_val({tag, " read byte"}, exp);
        observe(int'(b));
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: reset state
        chk_fields("R1 reset fields", 12'hF00);
        expect_val("R1 reset oe", 0);
        observe(int'(sda_oe));

        // R2: enable register write
        wr_txn(8'h00, 8'h05, "R2");
        chk_fields("R2 enables", 12'h500);

        // R4: select register, two patterns
        wr_txn(8'h08, 8'h1E, "R4");
        chk_fields("R4 selects all set", 12'h5F0);
        wr_txn(8'h08, 8'h0A, "R4");
        chk_fields("R4 selects mixed", 12'h550);

        // R5: select4 and trim
        wr_txn(8'h0A, 8'h0E, "R5");
        chk_fields("R5 sel4 trim", 12'h55E);

        // R6: read back through repeated START
        rd_txn(8'h00, 8'h05, "R6 idx00");
        rd_txn(8'h08, 8'h0A, "R6 idx08");
        rd_txn(8'h0A, 8'h0E, "R6 idx0A");
        wr_txn(8'h0A, 8'hF1, "R6");
        rd_txn(8'h0A, 8'h01, "R6 unused bits zero");
        chk_fields("R6 after F1 write", 12'h551);

        // R3: foreign address ignored
        bus_start();
        send_acked({7'b1001001, 1'b0}, 0, "R3 foreign addr nack");
        send_acked(8'h00, 0, "R3 index nack");
        send_acked(8'h00, 0, "R3 data nack");
        bus_stop();
        chk_fields("R3 fields unchanged", 12'h551);

        // R7: unmapped reads
        rd_txn(8'h03, 8'hFF, "R7 idx03");
        rd_txn(8'hFF, 8'hFF, "R7 idxFF");
        rd_txn(8'h09, 8'hFF, "R7 idx09");

        // R8: unmapped write acknowledged, no effect
        wr_txn(8'h01, 8'h00, "R8");
        chk_fields("R8 fields unchanged", 12'h551);
        rd_txn(8'h00, 8'h05, "R8 enables intact");

        // R10: STOP after the index byte
        bus_start();
        send_acked({ADDR, 1'b0}, 1, "R10 addr ack");
        send_acked(8'h00, 1, "R10 index ack");
        bus_stop();
        chk_fields("R10 aborted write", 12'h551);

        // R11: second data byte refused
        bus_start();
        send_acked({ADDR, 1'b0}, 1, "R11 addr ack");
        send_acked(8'h00, 1, "R11 index ack");
        send_acked(8'h03, 1, "R11 first data ack");
        send_acked(8'h0C, 0, "R11 second data nack");
        bus_stop();
        chk_fields("R11 only first byte written", 12'h351);
        rd_txn(8'h00, 8'h03, "R11 readback");

        // R9: summary of the edge monitor
        expect_val("R9 oe changes with clock high", 0);
        observe(r9_bad);

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule